// File: doc/BRIEF.md
# Global Shared-Memory Node Access Controller

This block sits beside one processor in a machine whose memory is spread across several nodes and addressed through one global space. A processor access carries a global address. The block splits that address into a home-node field and a word offset, then compares the node field with the node's own identifier. A local access is served from the node's memory bank inside the block. A remote access becomes a request packet on an outgoing request channel. The processor stays stalled until the matching read data or write acknowledgement comes back on the incoming response channel. A refused request is retried after a fixed pause.

The same block also serves other nodes. Request packets arriving from the network enter a small queue. A server pops each one, performs it on the local bank and returns a read response or a write acknowledgement on the outgoing response channel. When the queue is full, an arriving request is answered at once with a refusal packet and is not performed. Requests and responses travel on separate channels, so a response never waits behind a request.

The requester state machine has the states IDLE, LOCAL, SEND, WAIT, BACKOFF and DONE. Its transitions are:
- IDLE→LOCAL when an accepted access is local.
- IDLE→SEND when an accepted access is remote.
- LOCAL→DONE.
- SEND→WAIT when the request packet is taken.
- WAIT→DONE on the expected answer.
- WAIT→BACKOFF on a refusal.
- BACKOFF→SEND when the pause counter expires.
- DONE→IDLE.

The server state machine has the states SV_IDLE, SV_MEM and SV_REPLY. Its transitions are:
- SV_IDLE→SV_MEM when an entry is popped.
- SV_MEM→SV_REPLY.
- SV_REPLY→SV_IDLE when the reply is loaded into the output register. A pending refusal takes that register first.

Packet kind codes on every channel are: read request 0, write request 1, read response 2, write acknowledgement 3, refusal 4.

Top module: `shmem_node_ctrl`

## Requirements
- R1: A global address is {node[NODE_W-1:0], offset[OFF_W-1:0]} with the node field in the upper bits. An access is local exactly when the node field equals `node_id`. Otherwise it goes to the network.
- R2: A local access accepted on a clock edge emits no request packet. It raises `cpu_done` during the second cycle after acceptance, and a read then returns the last value stored at that offset.
- R3: A remote read emits one packet with kind 0, source `node_id`, destination equal to the node field, and address equal to the offset. The processor is held until a kind-2 response addressed to `node_id` arrives. `cpu_done` rises in the cycle after that response, and `cpu_rdata` equals the response data.
- R4: A remote write emits one packet with kind 1 that carries the write data. The write completes (`cpu_done`) only in the cycle after a kind-3 acknowledgement addressed to `node_id`.
- R5: At most one access is outstanding. `cpu_ready` is low from the cycle after acceptance until the cycle after `cpu_done`.
- R6: A kind-4 refusal received while waiting causes the identical request to be presented again. The outgoing valid stays low for exactly BACKOFF cycles after the cycle in which the refusal was taken.
- R7: An incoming kind-0 request is answered with kind 2 carrying the word at its address. An incoming kind-1 request stores its data and is answered with kind 3. Each reply has source `node_id`, destination equal to the request's source, and the request's address echoed.
- R8: While the incoming queue holds QDEPTH requests, a further request is answered with kind 4 (destination equal to the request's source, address echoed, data 0) and is not performed. `rqi_ready` stays low until that refusal has been loaded into the response output register.
- R9: Replies on the outgoing response channel are produced while the outgoing request channel is stalled.
- R10: An incoming response is ignored when no remote access is waiting, when its destination differs from `node_id`, or when its kind is neither the expected answer nor a refusal.
- R11: After reset, `cpu_ready` and `rqi_ready` are high, `cpu_done`, `rqo_valid` and `rso_valid` are low, and every memory word reads 0.
- R12: A valid packet on either outgoing channel keeps its valid and its fields unchanged until it is taken with ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | NODE_W | This node's identifier |
| cpu_valid | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | NODE_W+OFF_W | Global address {node, offset} |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access accepted when high with cpu_valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| rqo_valid | output | 1 | Outgoing request valid |
| rqo_ready | input | 1 | Network takes the outgoing request |
| rqo_kind | output | 3 | Outgoing request kind |
| rqo_src | output | NODE_W | Requesting node |
| rqo_dst | output | NODE_W | Home node |
| rqo_addr | output | OFF_W | Word offset at the home node |
| rqo_data | output | DATA_W | Write data (0 for reads) |
| rsi_valid | input | 1 | Incoming response valid |
| rsi_ready | output | 1 | Always high: responses are always sunk |
| rsi_kind | input | 3 | Incoming response kind |
| rsi_dst | input | NODE_W | Node the response is meant for |
| rsi_data | input | DATA_W | Response data |
| rqi_valid | input | 1 | Incoming request valid |
| rqi_ready | output | 1 | Incoming request taken |
| rqi_kind | input | 3 | Incoming request kind |
| rqi_src | input | NODE_W | Node that sent the request |
| rqi_addr | input | OFF_W | Offset into the local bank |
| rqi_data | input | DATA_W | Write data |
| rso_valid | output | 1 | Outgoing response valid |
| rso_ready | input | 1 | Network takes the outgoing response |
| rso_kind | output | 3 | Outgoing response kind |
| rso_src | output | NODE_W | This node |
| rso_dst | output | NODE_W | Node that sent the request |
| rso_addr | output | OFF_W | Echoed offset |
| rso_data | output | DATA_W | Read data (0 for acknowledgements and refusals) |

## Verification
Some wrong internal states show at the ports within a cycle or two:
- A requester stuck in the wrong state shows `cpu_ready` staying low, `cpu_done` at the wrong cycle, or a request packet on a local access. These appear by the second cycle after acceptance.
- A mis-sized pause counter moves the re-sent request earlier or later than BACKOFF idle cycles. The bench counts these cycles exactly.

Other faults only show later, through the response channel or the memory:
- A miscounted queue shows as a refusal on the wrong request, or none at all, once the fifth request of the stall sequence is sent.
- A refused request that wrongly reaches memory shows on the next read of its offset.
- Corrupted queue contents show as wrong reply fields or a wrong stored word. A later local read of that offset reveals the bad store.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    typedef enum logic [2:0] {
        PK_RD_REQ = 3'd0,
        PK_WR_REQ = 3'd1,
        PK_RD_RSP = 3'd2,
        PK_WR_ACK = 3'd3,
        PK_NACK   = 3'd4
    } pkt_kind_e;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_LOCAL,
        RQ_SEND,
        RQ_WAIT,
        RQ_BACKOFF,
        RQ_DONE
    } rq_state_e;

    typedef enum logic [1:0] {
        SV_IDLE,
        SV_MEM,
        SV_REPLY
    } sv_state_e;

endpackage

// File: rtl/shmem_local_ram.sv
module shmem_local_ram #(
    parameter int OFF_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [OFF_W-1:0]  a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [OFF_W-1:0]  b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    localparam int WORDS = 1 << OFF_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Port b (remote proxy) is written last, so it wins a same-word collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_en && a_we) mem[a_addr] <= a_wdata;
            if (b_en && b_we) mem[b_addr] <= b_wdata;
            if (a_en && !a_we) a_rdata <= mem[a_addr];
            if (b_en && !b_we) b_rdata <= mem[b_addr];
        end
    end
endmodule

// File: rtl/shmem_req_fifo.sv
module shmem_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = store[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/shmem_requester.sv
module shmem_requester
    import shmem_pkg::*;
#(
    parameter int NODE_W  = 2,
    parameter int OFF_W   = 4,
    parameter int DATA_W  = 8,
    parameter int BACKOFF = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NODE_W-1:0]        node_id,
    input  logic                     cpu_valid,
    input  logic                     cpu_we,
    input  logic [NODE_W+OFF_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic                     cpu_ready,
    output logic                     cpu_done,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     rqo_valid,
    input  logic                     rqo_ready,
    output logic [2:0]               rqo_kind,
    output logic [NODE_W-1:0]        rqo_src,
    output logic [NODE_W-1:0]        rqo_dst,
    output logic [OFF_W-1:0]         rqo_addr,
    output logic [DATA_W-1:0]        rqo_data,
    input  logic                     rsi_valid,
    output logic                     rsi_ready,
    input  logic [2:0]               rsi_kind,
    input  logic [NODE_W-1:0]        rsi_dst,
    input  logic [DATA_W-1:0]        rsi_data,
    output logic                     ram_en,
    output logic                     ram_we,
    output logic [OFF_W-1:0]         ram_addr,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata
);
    localparam int GA_W  = NODE_W + OFF_W;
    localparam int CNT_W = $clog2(BACKOFF + 1);

    rq_state_e         st_q, st_d;
    logic              we_q, loc_q;
    logic [NODE_W-1:0] dst_q;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] wdata_q, rsp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              rsp_hit, is_local;
    pkt_kind_e         want_kind;

    assign is_local  = (cpu_addr[GA_W-1:OFF_W] == node_id);
    assign want_kind = we_q ? PK_WR_ACK : PK_RD_RSP;
    assign rsp_hit   = rsi_valid && (rsi_dst == node_id) && (st_q == RQ_WAIT);
    assign rsi_ready = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RQ_IDLE:    if (cpu_valid) st_d = is_local ? RQ_LOCAL : RQ_SEND;
            RQ_LOCAL:   st_d = RQ_DONE;
            RQ_SEND:    if (rqo_ready) st_d = RQ_WAIT;
            RQ_WAIT: begin
                if (rsp_hit && rsi_kind == want_kind)     st_d = RQ_DONE;
                else if (rsp_hit && rsi_kind == PK_NACK)  st_d = RQ_BACKOFF;
            end
            RQ_BACKOFF: if (cnt_q == CNT_W'(BACKOFF - 1)) st_d = RQ_SEND;
            RQ_DONE:    st_d = RQ_IDLE;
            default:    st_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            loc_q   <= 1'b0;
            dst_q   <= '0;
            off_q   <= '0;
            wdata_q <= '0;
            rsp_q   <= '0;
            cnt_q   <= '0;
        end else begin
            if (st_q == RQ_IDLE && cpu_valid) begin
                we_q    <= cpu_we;
                loc_q   <= is_local;
                dst_q   <= cpu_addr[GA_W-1:OFF_W];
                off_q   <= cpu_addr[OFF_W-1:0];
                wdata_q <= cpu_wdata;
            end
            if (rsp_hit && rsi_kind == want_kind) rsp_q <= rsi_data;
            if (st_q == RQ_BACKOFF) cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= '0;
        end
    end

    always_comb begin
        cpu_ready = (st_q == RQ_IDLE);
        cpu_done  = (st_q == RQ_DONE);
        cpu_rdata = loc_q ? ram_rdata : rsp_q;
        rqo_valid = (st_q == RQ_SEND);
        rqo_kind  = we_q ? PK_WR_REQ : PK_RD_REQ;
        rqo_src   = node_id;
        rqo_dst   = dst_q;
        rqo_addr  = off_q;
        rqo_data  = we_q ? wdata_q : '0;
        ram_en    = (st_q == RQ_LOCAL);
        ram_we    = we_q;
        ram_addr  = off_q;
        ram_wdata = wdata_q;
    end

    // R12
    rqo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rqo_valid && !rqo_ready) |=> (rqo_valid && $stable(rqo_kind) &&
                                       $stable(rqo_dst) && $stable(rqo_addr) && $stable(rqo_data)));
    // R1 R3
    rqo_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rqo_valid |-> ((rqo_dst != node_id) &&
                       (rqo_kind == PK_RD_REQ || rqo_kind == PK_WR_REQ)));
    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ready) |-> $past(cpu_done));
endmodule

// File: rtl/shmem_proxy.sv
module shmem_proxy
    import shmem_pkg::*;
#(
    parameter int NODE_W = 2,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 8,
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] node_id,
    input  logic              rqi_valid,
    output logic              rqi_ready,
    input  logic [2:0]        rqi_kind,
    input  logic [NODE_W-1:0] rqi_src,
    input  logic [OFF_W-1:0]  rqi_addr,
    input  logic [DATA_W-1:0] rqi_data,
    output logic              rso_valid,
    input  logic              rso_ready,
    output logic [2:0]        rso_kind,
    output logic [NODE_W-1:0] rso_src,
    output logic [NODE_W-1:0] rso_dst,
    output logic [OFF_W-1:0]  rso_addr,
    output logic [DATA_W-1:0] rso_data,
    output logic              ram_en,
    output logic              ram_we,
    output logic [OFF_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int EW = 1 + NODE_W + OFF_W + DATA_W;

    sv_state_e         sv_q, sv_d;
    logic              full, empty, push, pop, refuse;
    logic [EW-1:0]     push_d, pop_d;
    logic              nack_q;
    logic [NODE_W-1:0] nack_dst_q;
    logic [OFF_W-1:0]  nack_addr_q;
    logic              e_we_q;
    logic [NODE_W-1:0] e_src_q;
    logic [OFF_W-1:0]  e_addr_q;
    logic [DATA_W-1:0] e_data_q;
    logic              ov_q;
    logic [2:0]        okind_q;
    logic [NODE_W-1:0] odst_q;
    logic [OFF_W-1:0]  oaddr_q;
    logic [DATA_W-1:0] odata_q;
    logic              out_free, load_nack, load_rep;

    assign rqi_ready = !nack_q;
    assign push      = rqi_valid && rqi_ready && !full;
    assign refuse    = rqi_valid && rqi_ready && full;
    assign push_d    = {(rqi_kind == PK_WR_REQ), rqi_src, rqi_addr, rqi_data};
    assign pop       = (sv_q == SV_IDLE) && !empty;
    assign out_free  = !ov_q || rso_ready;
    assign load_nack = out_free && nack_q;
    assign load_rep  = out_free && !nack_q && (sv_q == SV_REPLY);

    shmem_req_fifo #(.WIDTH(EW), .DEPTH(QDEPTH)) queue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_d),
        .pop       (pop),
        .pop_data  (pop_d),
        .full      (full),
        .empty     (empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv_q <= SV_IDLE;
        else        sv_q <= sv_d;
    end

    always_comb begin
        sv_d = sv_q;
        unique case (sv_q)
            SV_IDLE:  if (pop) sv_d = SV_MEM;
            SV_MEM:   sv_d = SV_REPLY;
            SV_REPLY: if (load_rep) sv_d = SV_IDLE;
            default:  sv_d = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nack_q      <= 1'b0;
            nack_dst_q  <= '0;
            nack_addr_q <= '0;
            {e_we_q, e_src_q, e_addr_q, e_data_q} <= '0;
            ov_q    <= 1'b0;
            okind_q <= '0;
            odst_q  <= '0;
            oaddr_q <= '0;
            odata_q <= '0;
        end else begin
            if (refuse) begin
                nack_q      <= 1'b1;
                nack_dst_q  <= rqi_src;
                nack_addr_q <= rqi_addr;
            end else if (load_nack) begin
                nack_q <= 1'b0;
            end
            if (pop) {e_we_q, e_src_q, e_addr_q, e_data_q} <= pop_d;
            if (load_nack) begin
                ov_q    <= 1'b1;
                okind_q <= PK_NACK;
                odst_q  <= nack_dst_q;
                oaddr_q <= nack_addr_q;
                odata_q <= '0;
            end else if (load_rep) begin
                ov_q    <= 1'b1;
                okind_q <= e_we_q ? PK_WR_ACK : PK_RD_RSP;
                odst_q  <= e_src_q;
                oaddr_q <= e_addr_q;
                odata_q <= e_we_q ? '0 : ram_rdata;
            end else if (rso_ready) begin
                ov_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rso_valid = ov_q;
        rso_kind  = okind_q;
        rso_src   = node_id;
        rso_dst   = odst_q;
        rso_addr  = oaddr_q;
        rso_data  = odata_q;
        ram_en    = (sv_q == SV_MEM);
        ram_we    = e_we_q;
        ram_addr  = e_addr_q;
        ram_wdata = e_data_q;
    end

    // R12
    rso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rso_valid && !rso_ready) |=> (rso_valid && $stable(rso_kind) &&
                                       $stable(rso_dst) && $stable(rso_addr) && $stable(rso_data)));
    // R7 R8
    rso_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rso_valid |-> (rso_kind == PK_RD_RSP || rso_kind == PK_WR_ACK || rso_kind == PK_NACK));
endmodule

// File: rtl/shmem_node_ctrl.sv
module shmem_node_ctrl #(
    parameter int NODE_W  = 2,
    parameter int OFF_W   = 4,
    parameter int DATA_W  = 8,
    parameter int QDEPTH  = 2,
    parameter int BACKOFF = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NODE_W-1:0]       node_id,
    input  logic                    cpu_valid,
    input  logic                    cpu_we,
    input  logic [NODE_W+OFF_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]       cpu_wdata,
    output logic                    cpu_ready,
    output logic                    cpu_done,
    output logic [DATA_W-1:0]       cpu_rdata,
    output logic                    rqo_valid,
    input  logic                    rqo_ready,
    output logic [2:0]              rqo_kind,
    output logic [NODE_W-1:0]       rqo_src,
    output logic [NODE_W-1:0]       rqo_dst,
    output logic [OFF_W-1:0]        rqo_addr,
    output logic [DATA_W-1:0]       rqo_data,
    input  logic                    rsi_valid,
    output logic                    rsi_ready,
    input  logic [2:0]              rsi_kind,
    input  logic [NODE_W-1:0]       rsi_dst,
    input  logic [DATA_W-1:0]       rsi_data,
    input  logic                    rqi_valid,
    output logic                    rqi_ready,
    input  logic [2:0]              rqi_kind,
    input  logic [NODE_W-1:0]       rqi_src,
    input  logic [OFF_W-1:0]        rqi_addr,
    input  logic [DATA_W-1:0]       rqi_data,
    output logic                    rso_valid,
    input  logic                    rso_ready,
    output logic [2:0]              rso_kind,
    output logic [NODE_W-1:0]       rso_src,
    output logic [NODE_W-1:0]       rso_dst,
    output logic [OFF_W-1:0]        rso_addr,
    output logic [DATA_W-1:0]       rso_data
);
    logic              a_en, a_we, b_en, b_we;
    logic [OFF_W-1:0]  a_addr, b_addr;
    logic [DATA_W-1:0] a_wdata, a_rdata, b_wdata, b_rdata;

    shmem_local_ram #(.OFF_W(OFF_W), .DATA_W(DATA_W)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    shmem_requester #(.NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .BACKOFF(BACKOFF)) req_i (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .rqo_valid(rqo_valid), .rqo_ready(rqo_ready), .rqo_kind(rqo_kind), .rqo_src(rqo_src),
        .rqo_dst(rqo_dst), .rqo_addr(rqo_addr), .rqo_data(rqo_data),
        .rsi_valid(rsi_valid), .rsi_ready(rsi_ready), .rsi_kind(rsi_kind),
        .rsi_dst(rsi_dst), .rsi_data(rsi_data),
        .ram_en(a_en), .ram_we(a_we), .ram_addr(a_addr), .ram_wdata(a_wdata), .ram_rdata(a_rdata)
    );

    shmem_proxy #(.NODE_W(NODE_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH)) proxy_i (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .rqi_valid(rqi_valid), .rqi_ready(rqi_ready), .rqi_kind(rqi_kind), .rqi_src(rqi_src),
        .rqi_addr(rqi_addr), .rqi_data(rqi_data),
        .rso_valid(rso_valid), .rso_ready(rso_ready), .rso_kind(rso_kind), .rso_src(rso_src),
        .rso_dst(rso_dst), .rso_addr(rso_addr), .rso_data(rso_data),
        .ram_en(b_en), .ram_we(b_we), .ram_addr(b_addr), .ram_wdata(b_wdata), .ram_rdata(b_rdata)
    );
endmodule

// File: tb/shmem_node_ctrl_tb_top.sv
module shmem_node_ctrl_tb_top;
    import shmem_pkg::*;

    localparam int NW = 2, OW = 4, DW = 8, QD = 2, BO = 3;
    localparam logic [NW-1:0] ME = 2'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [NW+OW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ready, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic rqo_valid, rqo_ready = 1'b1;
    logic [2:0] rqo_kind;
    logic [NW-1:0] rqo_src, rqo_dst;
    logic [OW-1:0] rqo_addr;
    logic [DW-1:0] rqo_data;
    logic rsi_valid = 1'b0, rsi_ready;
    logic [2:0] rsi_kind = '0;
    logic [NW-1:0] rsi_dst = '0;
    logic [DW-1:0] rsi_data = '0;
    logic rqi_valid = 1'b0, rqi_ready;
    logic [2:0] rqi_kind = '0;
    logic [NW-1:0] rqi_src = '0;
    logic [OW-1:0] rqi_addr = '0;
    logic [DW-1:0] rqi_data = '0;
    logic rso_valid, rso_ready = 1'b1;
    logic [2:0] rso_kind;
    logic [NW-1:0] rso_src, rso_dst;
    logic [OW-1:0] rso_addr;
    logic [DW-1:0] rso_data;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    shmem_node_ctrl #(.NODE_W(NW), .OFF_W(OW), .DATA_W(DW), .QDEPTH(QD), .BACKOFF(BO)) dut_i (
        .clk(clk), .rst_n(rst_n), .node_id(ME),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .rqo_valid(rqo_valid), .rqo_ready(rqo_ready), .rqo_kind(rqo_kind), .rqo_src(rqo_src),
        .rqo_dst(rqo_dst), .rqo_addr(rqo_addr), .rqo_data(rqo_data),
        .rsi_valid(rsi_valid), .rsi_ready(rsi_ready), .rsi_kind(rsi_kind), .rsi_dst(rsi_dst),
        .rsi_data(rsi_data),
        .rqi_valid(rqi_valid), .rqi_ready(rqi_ready), .rqi_kind(rqi_kind), .rqi_src(rqi_src),
        .rqi_addr(rqi_addr), .rqi_data(rqi_data),
        .rso_valid(rso_valid), .rso_ready(rso_ready), .rso_kind(rso_kind), .rso_src(rso_src),
        .rso_dst(rso_dst), .rso_addr(rso_addr), .rso_data(rso_data)
    );

    function automatic logic [DW-1:0] pattern(input int off);
        return 8'((off * 13 + 5) % 256);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic cpu_issue(input logic we, input logic [NW-1:0] node, input logic [OW-1:0] off,
                             input logic [DW-1:0] wd);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = {node, off}; cpu_wdata = wd;
        for (int t = 0; t < 50 && !cpu_ready; t++) @(negedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    // Ends at the negedge of the done cycle.
    task automatic local_access(input logic we, input logic [OW-1:0] off, input logic [DW-1:0] wd,
                                input logic [DW-1:0] exp);
        cpu_issue(we, ME, off, wd);
        chk("R2", "done early", int'(cpu_done), 0);
        chk("R1", "local sent packet", int'(rqo_valid), 0);
        chk("R5", "ready after accept", int'(cpu_ready), 0);
        @(negedge clk);
        chk("R2", "done at 2nd cycle", int'(cpu_done), 1);
        if (!we) chk("R2", "local read data", int'(cpu_rdata), int'(exp));
        @(negedge clk);
        chk("R5", "ready back", int'(cpu_ready), 1);
    endtask

    task automatic net_take(input logic [2:0] kind, input logic [NW-1:0] dst,
                            input logic [OW-1:0] off, input logic [DW-1:0] data);
        int t;
        t = 0;
        while (!rqo_valid && t < 50) begin @(negedge clk); t++; end
        chk("R3", "request kind", int'(rqo_kind), int'(kind));
        chk("R3", "request src", int'(rqo_src), int'(ME));
        chk("R1", "request dst", int'(rqo_dst), int'(dst));
        chk("R3", "request addr", int'(rqo_addr), int'(off));
        chk("R4", "request data", int'(rqo_data), int'(data));
        @(negedge clk);
    endtask

    task automatic net_reply(input logic [2:0] kind, input logic [NW-1:0] dst, input logic [DW-1:0] data);
        @(negedge clk);
        rsi_valid = 1'b1; rsi_kind = kind; rsi_dst = dst; rsi_data = data;
        @(negedge clk);
        rsi_valid = 1'b0;
    endtask

    task automatic remote_read(input logic [NW-1:0] node, input logic [OW-1:0] off, input logic [DW-1:0] d);
        cpu_issue(1'b0, node, off, '0);
        net_take(PK_RD_REQ, node, off, '0);
        chk("R3", "held while waiting", int'(cpu_ready), 0);
        chk("R3", "no early done", int'(cpu_done), 0);
        net_reply(PK_RD_RSP, ME, d);
        chk("R3", "read done", int'(cpu_done), 1);
        chk("R3", "read data", int'(cpu_rdata), int'(d));
        @(negedge clk);
        chk("R5", "ready after read", int'(cpu_ready), 1);
    endtask

    task automatic remote_write(input logic [NW-1:0] node, input logic [OW-1:0] off, input logic [DW-1:0] d);
        cpu_issue(1'b1, node, off, d);
        net_take(PK_WR_REQ, node, off, d);
        chk("R4", "no done before ack", int'(cpu_done), 0);
        net_reply(PK_WR_ACK, ME, '0);
        chk("R4", "write done after ack", int'(cpu_done), 1);
        @(negedge clk);
    endtask

    task automatic rqi_send(input logic [2:0] kind, input logic [NW-1:0] src,
                            input logic [OW-1:0] off, input logic [DW-1:0] d);
        @(negedge clk);
        rqi_valid = 1'b1; rqi_kind = kind; rqi_src = src; rqi_addr = off; rqi_data = d;
        for (int t = 0; t < 50 && !rqi_ready; t++) @(negedge clk);
        @(negedge clk);
        rqi_valid = 1'b0;
    endtask

    task automatic rso_take(output int kind, output int src, output int dst, output int off, output int d);
        int t;
        t = 0;
        while (!rso_valid && t < 100) begin @(negedge clk); t++; end
        kind = int'(rso_kind); src = int'(rso_src); dst = int'(rso_dst);
        off = int'(rso_addr); d = int'(rso_data);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int k, s, d, o, v, nacks, n;
        logic [NW-1:0] nodes [3];
        nodes[0] = 2'd0; nodes[1] = 2'd2; nodes[2] = 2'd3;

        // R11 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "cpu_ready", int'(cpu_ready), 1);
        chk("R11", "cpu_done", int'(cpu_done), 0);
        chk("R11", "rqo_valid", int'(rqo_valid), 0);
        chk("R11", "rso_valid", int'(rso_valid), 0);
        chk("R11", "rqi_ready", int'(rqi_ready), 1);
        local_access(1'b0, 4'd7, '0, '0); // R11 memory cleared

        // R1 R2 exhaustive local write/read
        for (int i = 0; i < (1 << OW); i++) local_access(1'b1, 4'(i), pattern(i), '0);
        for (int i = 0; i < (1 << OW); i++) local_access(1'b0, 4'(i), '0, pattern(i));

        // R7 proxy reads every word, then writes four
        for (int i = 0; i < (1 << OW); i++) begin
            rqi_send(PK_RD_REQ, 2'd2, 4'(i), '0);
            rso_take(k, s, d, o, v);
            chk("R7", "read reply kind", k, int'(PK_RD_RSP));
            chk("R7", "reply src", s, int'(ME));
            chk("R7", "reply dst", d, 2);
            chk("R7", "reply addr", o, i);
            chk("R7", "reply data", v, int'(pattern(i)));
        end
        for (int i = 0; i < 4; i++) begin
            rqi_send(PK_WR_REQ, 2'd3, 4'(i), 8'(200 + i));
            rso_take(k, s, d, o, v);
            chk("R7", "write ack kind", k, int'(PK_WR_ACK));
            chk("R7", "ack dst", d, 3);
            chk("R7", "ack addr", o, i);
        end
        for (int i = 0; i < 4; i++) local_access(1'b0, 4'(i), '0, 8'(200 + i));

        // R1 R3 R4 remote sweep
        for (int j = 0; j < 3; j++) begin
            for (int i = 0; i < (1 << OW); i += 5) begin
                remote_write(nodes[j], 4'(i), 8'(nodes[j] * 40 + i));
                remote_read(nodes[j], 4'(i), 8'(255 - nodes[j] * 20 - i));
            end
        end

        // R10 stray responses
        net_reply(PK_RD_RSP, ME, 8'd9);
        chk("R10", "idle stray done", int'(cpu_done), 0);
        chk("R10", "idle stray ready", int'(cpu_ready), 1);
        cpu_issue(1'b0, 2'd2, 4'd6, '0);
        net_take(PK_RD_REQ, 2'd2, 4'd6, '0);
        net_reply(PK_RD_RSP, 2'd3, 8'd11);
        chk("R10", "wrong dst done", int'(cpu_done), 0);
        net_reply(PK_WR_ACK, ME, 8'd12);
        chk("R10", "wrong kind done", int'(cpu_done), 0);
        chk("R10", "no re-send", int'(rqo_valid), 0);
        net_reply(PK_RD_RSP, ME, 8'd33);
        chk("R10", "proper reply done", int'(cpu_done), 1);
        chk("R10", "proper reply data", int'(cpu_rdata), 33);
        @(negedge clk);

        // R6 refusal and back-off
        cpu_issue(1'b1, 2'd3, 4'd9, 8'd77);
        net_take(PK_WR_REQ, 2'd3, 4'd9, 8'd77);
        net_reply(PK_NACK, ME, '0);
        n = 0;
        while (!rqo_valid && n < 20) begin
            if (cpu_done) chk("R6", "done during backoff", 1, 0);
            @(negedge clk); n++;
        end
        chk("R6", "backoff idle cycles", n, BO);
        net_take(PK_WR_REQ, 2'd3, 4'd9, 8'd77);
        net_reply(PK_WR_ACK, ME, '0);
        chk("R6", "done after retry ack", int'(cpu_done), 1);
        @(negedge clk);

        // R9 R12 responses flow while request channel stalls
        rqo_ready = 1'b0;
        cpu_issue(1'b0, 2'd2, 4'd4, '0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R12", "stalled valid held", int'(rqo_valid), 1);
            chk("R12", "stalled addr held", int'(rqo_addr), 4);
        end
        rqi_send(PK_RD_REQ, 2'd0, 4'd4, '0);
        rso_take(k, s, d, o, v);
        chk("R9", "reply during stall kind", k, int'(PK_RD_RSP));
        chk("R9", "reply during stall data", v, int'(pattern(4)));
        rqo_ready = 1'b1;
        net_take(PK_RD_REQ, 2'd2, 4'd4, '0);
        net_reply(PK_RD_RSP, ME, 8'd90);
        chk("R9", "stalled read completes", int'(cpu_rdata), 90);
        @(negedge clk);

        // R8 queue full refusal
        rso_ready = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (i == 4) chk("R8", "ready before refusal", int'(rqi_ready), 1);
            rqi_send(PK_WR_REQ, 2'd2, 4'(10 + i), 8'(100 + i));
            repeat (6) @(negedge clk);
        end
        chk("R8", "input held after refusal", int'(rqi_ready), 0);
        rso_ready = 1'b1;
        nacks = 0;
        for (int i = 0; i < 5; i++) begin
            rso_take(k, s, d, o, v);
            chk("R8", "reply dst", d, 2);
            if (o == 14) begin
                nacks++;
                chk("R8", "refusal kind", k, int'(PK_NACK));
                chk("R8", "refusal data", v, 0);
            end else begin
                chk("R8", "accepted kind", k, int'(PK_WR_ACK));
            end
        end
        chk("R8", "refusal count", nacks, 1);
        chk("R8", "input ready again", int'(rqi_ready), 1);
        for (int i = 0; i < 4; i++) local_access(1'b0, 4'(10 + i), '0, 8'(100 + i));
        local_access(1'b0, 4'd14, '0, pattern(14));

        summary();
        $finish;
    end
endmodule